// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects sixteen external interrupt request lines and drives a single interrupt output toward a processor. Every line gets its own trigger condition, chosen from two level polarities and two edge directions, and its own three-bit priority. A level of zero switches the line off. A global threshold hides every request whose priority does not exceed it. The remaining requests compete, and the winner is reported in a status word.

Software programs the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Incoming lines are first brought into the clock domain by a synchronizer. In the edge modes, an edge sets a per-line latch, and only software can clear it, by writing that line's index to a clear command register. A handler reads the current-status word to find which line to serve and at what priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable bit, every trigger mode, every priority level and the threshold are zero, `cpu_irq` is low, and the current-status word at offset 0xA0 reads 0x0001_0000.
- R2: Bit 0 of the control word at offset 0x00 gates delivery. While it is 0, `cpu_irq` stays low, but the current-status word still reports the winner.
- R3: The trigger mode of source n is two bits. It is held in the mode word at offset 0x04 (sources 0-7) or 0x08 (sources 8-15), at bits (n mod 8)*2+1:(n mod 8)*2. Bits 31:16 of these words read zero.
- R4: The priority of source n is held in the word at offset 0x10 + 4*(n/2). An even source uses bits 2:0 and an odd source uses bits 10:8, and all other bits read zero. A source whose priority is 0 never wins.
- R5: Mode 00 requests while the synchronized line is low, and mode 01 requests while it is high. A change on a line reaches `cpu_irq` on the second rising clock edge after it is applied.
- R6: Mode 10 latches on a falling edge and mode 11 latches on a rising edge of the synchronized line. The latch is set on the third clock edge after the line changes, and it holds after the line returns.
- R7: A write to offset 0x60 with bit 8 set clears the edge latch of the source whose index is in bits 3:0. The same write with bit 8 clear changes nothing.
- R8: A source is eligible only when its priority is strictly greater than the threshold held in bits 2:0 of offset 0x40. The other bits of that word read zero.
- R9: Among eligible sources, the highest priority wins, and equal priorities go to the lower source index. `cpu_irq` is high while a winner exists and the block is enabled.
- R10: In the current-status word at 0xA0, bit 16 is 1 when no source is eligible, bits 10:8 hold the winner's priority and bits 4:0 its index. With no winner these fields are zero.
- R11: Offsets not listed above read zero and ignore writes. This includes the status word at 0x80. The clear command at 0x60 reads zero, and the current-status word cannot be written.
- R12: Moving a source out of an edge mode discards its latch, so returning to an edge mode needs a fresh edge before it requests again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 16 | External request lines, asynchronous |
| cpu_irq | output | 1 | Interrupt output to the processor |

## Verification
The bound checker watches, on every cycle, several properties that hold regardless of stimulus:
- a disabled controller never raises `cpu_irq`;
- a reported winner is eligible, has a nonzero priority and is above the threshold;
- an edge latch rises only while its source is in an edge mode, and holds unless a clear for that source arrives;
- the no-pending flag agrees with the arbiter;
- offset 0x80 reads zero.

Only the bench scenarios can show the rest: synchronizer latency, tie-breaking toward the lower index, the exact bit packing of the mode and priority words, that a clear without its arm bit is ignored, and that a latch is dropped when the mode changes.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

   localparam int unsigned REG_W = 32;

   // register byte offsets; software decodes these
   localparam int unsigned OFS_ENABLE     = 32'h00;
   localparam int unsigned OFS_MODE_BASE  = 32'h04;
   localparam int unsigned OFS_LEVEL_BASE = 32'h10;
   localparam int unsigned OFS_MASK       = 32'h40;
   localparam int unsigned OFS_CLEAR      = 32'h60;
   localparam int unsigned OFS_STATUS     = 32'h80;
   localparam int unsigned OFS_CURRENT    = 32'hA0;

   // field positions
   localparam int unsigned SRC_PER_MODE_REG = 8;
   localparam int unsigned SRC_PER_LVL_REG  = 2;
   localparam int unsigned LVL_HI_LSB       = 8;
   localparam int unsigned CLR_ARM_BIT      = 8;
   localparam int unsigned CLR_IDX_W        = 4;
   localparam int unsigned NONE_FLAG_BIT    = 16;
   localparam int unsigned CUR_LVL_LSB      = 8;
   localparam int unsigned CUR_ID_W         = 5;

   // trigger mode: bit 1 selects edge, bit 0 selects polarity
   localparam int unsigned TRIG_EDGE_BIT = 1;
   localparam int unsigned TRIG_POL_BIT  = 0;

   typedef enum logic [1:0] {
      TRIG_LVL_LOW  = 2'b00,
      TRIG_LVL_HIGH = 2'b01,
      TRIG_FALLING  = 2'b10,
      TRIG_RISING   = 2'b11
   } trig_mode_e;

endpackage

// File: rtl/irq_src_frontend.sv
`timescale 1ns/1ps
module irq_src_frontend
   import prio_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_i,
   input  logic [1:0] mode_i,
   input  logic       clr_i,
   output logic       req_o,
   output logic       latch_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   line_s;
   logic                   edge_hit;
   logic                   is_edge;
   logic                   pol;

   assign line_s  = sync_q[SYNC_STAGES-1];
   assign is_edge = mode_i[TRIG_EDGE_BIT];
   assign pol     = mode_i[TRIG_POL_BIT];

   // polarity bit picks rising (1) or falling (0)
   assign edge_hit = pol ? (line_s & ~prev_q) : (~line_s & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         prev_q <= line_s;
         if (!is_edge) begin
            latch_q <= 1'b0;
         end else begin
            latch_q <= edge_hit | (latch_q & ~clr_i);
         end
      end
   end

   assign req_o   = is_edge ? latch_q : (line_s == pol);
   assign latch_o = latch_q;

endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned LVL_W   = 3,
   parameter int unsigned ID_W    = 4
) (
   input  logic [NUM_SRC-1:0]       req_i,
   input  logic [LVL_W*NUM_SRC-1:0] level_i,
   input  logic [LVL_W-1:0]         mask_i,
   output logic [NUM_SRC-1:0]       elig_o,
   output logic                     valid_o,
   output logic [ID_W-1:0]          id_o,
   output logic [LVL_W-1:0]         lvl_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig_o[g] = req_i[g] && (level_i[LVL_W*g +: LVL_W] > mask_i);
   end

   logic             best_v;
   logic [ID_W-1:0]  best_id;
   logic [LVL_W-1:0] best_lvl;

   // ascending scan with strict compare keeps the lower index on ties
   always_comb begin
      best_v   = 1'b0;
      best_id  = '0;
      best_lvl = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig_o[i] && (!best_v || (level_i[LVL_W*i +: LVL_W] > best_lvl))) begin
            best_v   = 1'b1;
            best_id  = ID_W'(i);
            best_lvl = level_i[LVL_W*i +: LVL_W];
         end
      end
   end

   assign valid_o = best_v;
   assign id_o    = best_id;
   assign lvl_o   = best_lvl;

endmodule

// File: rtl/prio_irq_regs.sv
`timescale 1ns/1ps
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned LVL_W   = 3,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned ID_W    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_we,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   output logic                     ctrl_en_o,
   output logic [2*NUM_SRC-1:0]     mode_o,
   output logic [LVL_W*NUM_SRC-1:0] level_o,
   output logic [LVL_W-1:0]         mask_o,
   output logic [NUM_SRC-1:0]       clr_o,
   input  logic                     cur_valid_i,
   input  logic [ID_W-1:0]          cur_id_i,
   input  logic [LVL_W-1:0]         cur_lvl_i
);

   localparam int unsigned N_MODE_REGS = NUM_SRC / SRC_PER_MODE_REG;
   localparam int unsigned N_LVL_REGS  = NUM_SRC / SRC_PER_LVL_REG;
   localparam int unsigned MODE_BITS   = 2 * SRC_PER_MODE_REG;

   logic                     en_q;
   logic [2*NUM_SRC-1:0]     mode_q;
   logic [LVL_W*NUM_SRC-1:0] lvl_q;
   logic [LVL_W-1:0]         mask_q;
   logic                     clr_arm;
   logic                     unused_wdata;

   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= '0;
         lvl_q  <= '0;
         mask_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(OFS_ENABLE)) begin
            en_q <= bus_wdata[0];
         end
         for (int k = 0; k < N_MODE_REGS; k++) begin
            if (bus_addr == ADDR_W'(OFS_MODE_BASE + 4 * k)) begin
               mode_q[MODE_BITS*k +: MODE_BITS] <= bus_wdata[MODE_BITS-1:0];
            end
         end
         for (int k = 0; k < N_LVL_REGS; k++) begin
            if (bus_addr == ADDR_W'(OFS_LEVEL_BASE + 4 * k)) begin
               lvl_q[LVL_W*(2*k)   +: LVL_W] <= bus_wdata[LVL_W-1:0];
               lvl_q[LVL_W*(2*k+1) +: LVL_W] <= bus_wdata[LVL_HI_LSB +: LVL_W];
            end
         end
         if (bus_addr == ADDR_W'(OFS_MASK)) begin
            mask_q <= bus_wdata[LVL_W-1:0];
         end
      end
   end

   // clear command is a single-cycle pulse decoded from the write
   assign clr_arm = bus_we && (bus_addr == ADDR_W'(OFS_CLEAR)) && bus_wdata[CLR_ARM_BIT];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
      assign clr_o[g] = clr_arm && (bus_wdata[CLR_IDX_W-1:0] == CLR_IDX_W'(g));
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_ENABLE)) begin
         bus_rdata[0] = en_q;
      end
      for (int k = 0; k < N_MODE_REGS; k++) begin
         if (bus_addr == ADDR_W'(OFS_MODE_BASE + 4 * k)) begin
            bus_rdata[MODE_BITS-1:0] = mode_q[MODE_BITS*k +: MODE_BITS];
         end
      end
      for (int k = 0; k < N_LVL_REGS; k++) begin
         if (bus_addr == ADDR_W'(OFS_LEVEL_BASE + 4 * k)) begin
            bus_rdata[LVL_W-1:0]             = lvl_q[LVL_W*(2*k)   +: LVL_W];
            bus_rdata[LVL_HI_LSB +: LVL_W]   = lvl_q[LVL_W*(2*k+1) +: LVL_W];
         end
      end
      if (bus_addr == ADDR_W'(OFS_MASK)) begin
         bus_rdata[LVL_W-1:0] = mask_q;
      end
      if (bus_addr == ADDR_W'(OFS_CURRENT)) begin
         bus_rdata[NONE_FLAG_BIT]          = ~cur_valid_i;
         bus_rdata[CUR_LVL_LSB +: LVL_W]   = cur_lvl_i;
         bus_rdata[ID_W-1:0]               = cur_id_i;
      end
   end

   assign ctrl_en_o = en_q;
   assign mode_o    = mode_q;
   assign level_o   = lvl_q;
   assign mask_o    = mask_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_SRC-1:0] irq_lines,
   output logic               cpu_irq
);

   localparam int unsigned ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   // elaboration-time parameter checks
   if ((NUM_SRC % SRC_PER_MODE_REG) != 0 || NUM_SRC == 0 || NUM_SRC > 16) begin : g_bad_src
      $error("NUM_SRC must be 8 or 16 to fit the register map");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must lie in 1..8");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ID_W > CUR_ID_W) begin : g_bad_id
      $error("source index does not fit the status field");
   end

   logic                     ctrl_en;
   logic [2*NUM_SRC-1:0]     mode_vec;
   logic [LVL_W*NUM_SRC-1:0] level_vec;
   logic [LVL_W-1:0]         mask_lvl;
   logic [NUM_SRC-1:0]       clr_vec;
   logic [NUM_SRC-1:0]       req_vec;
   logic [NUM_SRC-1:0]       latch_vec;
   logic [NUM_SRC-1:0]       mode_edge_vec;
   logic [NUM_SRC-1:0]       elig_vec;
   logic                     win_valid;
   logic [ID_W-1:0]          win_id;
   logic [LVL_W-1:0]         win_lvl;

   prio_irq_regs #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .ADDR_W  (ADDR_W),
      .ID_W    (ID_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_we      (bus_we),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .ctrl_en_o   (ctrl_en),
      .mode_o      (mode_vec),
      .level_o     (level_vec),
      .mask_o      (mask_lvl),
      .clr_o       (clr_vec),
      .cur_valid_i (win_valid),
      .cur_id_i    (win_id),
      .cur_lvl_i   (win_lvl)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irq_src_frontend #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_fe (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (irq_lines[g]),
         .mode_i  (mode_vec[2*g +: 2]),
         .clr_i   (clr_vec[g]),
         .req_o   (req_vec[g]),
         .latch_o (latch_vec[g])
      );
      assign mode_edge_vec[g] = mode_vec[2*g + TRIG_EDGE_BIT];
   end

   irq_prio_arbiter #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .ID_W    (ID_W)
   ) u_arb (
      .req_i   (req_vec),
      .level_i (level_vec),
      .mask_i  (mask_lvl),
      .elig_o  (elig_vec),
      .valid_o (win_valid),
      .id_o    (win_id),
      .lvl_o   (win_lvl)
   );

   assign cpu_irq = ctrl_en & win_valid;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned LVL_W   = 3,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned ID_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_rdata,
   input logic               cpu_irq,
   input logic               ctrl_en,
   input logic               win_valid,
   input logic [ID_W-1:0]    win_id,
   input logic [LVL_W-1:0]   win_lvl,
   input logic [LVL_W-1:0]   mask_lvl,
   input logic [NUM_SRC-1:0] elig_vec,
   input logic [NUM_SRC-1:0] latch_vec,
   input logic [NUM_SRC-1:0] mode_edge_vec,
   input logic [NUM_SRC-1:0] clr_vec
);

   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> !cpu_irq);

   assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_lvl != '0));

   assert_above_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_lvl > mask_lvl));

   assert_winner_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> elig_vec[win_id]);

   assert_none_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(32'hA0)) |-> (bus_rdata[16] == !win_valid));

   assert_status_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(32'h80)) |-> (bus_rdata == 32'h0));

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lat
      assert_latch_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(latch_vec[g]) |-> $past(mode_edge_vec[g]));

      assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_vec[g] && mode_edge_vec[g] && !clr_vec[g]) |=> latch_vec[g]);

      assert_latch_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !mode_edge_vec[g] |=> !latch_vec[g]);
   end

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .LVL_W   (LVL_W),
   .ADDR_W  (ADDR_W),
   .ID_W    (ID_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .bus_rdata     (bus_rdata),
   .cpu_irq       (cpu_irq),
   .ctrl_en       (ctrl_en),
   .win_valid     (win_valid),
   .win_id        (win_id),
   .win_lvl       (win_lvl),
   .mask_lvl      (mask_lvl),
   .elig_vec      (elig_vec),
   .latch_vec     (latch_vec),
   .mode_edge_vec (mode_edge_vec),
   .clr_vec       (clr_vec)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'hA0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_lines = 16'hFFFF;
   logic        cpu_irq;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    cmp_on = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_lines (irq_lines),
      .cpu_irq   (cpu_irq)
   );

   // ---------------- behavioural reference model ----------------
   bit m_en;
   int m_mode [16];
   int m_lvl  [16];
   int m_mask;
   bit ms1 [16];
   bit ms2 [16];
   bit mprv[16];
   bit mlat[16];
   bit t_rise, t_fall, t_hit, t_clr;
   int t_base, t_k;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_mask = 0;
         for (int i = 0; i < 16; i++) begin
            m_mode[i] = 0; m_lvl[i] = 0;
            ms1[i] = 0; ms2[i] = 0; mprv[i] = 0; mlat[i] = 0;
         end
      end else begin
         for (int i = 0; i < 16; i++) begin
            t_rise = ms2[i] && !mprv[i];
            t_fall = !ms2[i] && mprv[i];
            t_hit  = (m_mode[i] == 3) ? t_rise : t_fall;
            t_clr  = bus_we && (bus_addr == 8'h60) && bus_wdata[8] && (bus_wdata[3:0] == 4'(i));
            if (m_mode[i] < 2) mlat[i] = 0;
            else mlat[i] = t_hit || (mlat[i] && !t_clr);
            mprv[i] = ms2[i];
            ms2[i]  = ms1[i];
            ms1[i]  = irq_lines[i];
         end
         if (bus_we) begin
            if (bus_addr == 8'h00) m_en = bus_wdata[0];
            if (bus_addr == 8'h04 || bus_addr == 8'h08) begin
               t_base = (bus_addr == 8'h08) ? 8 : 0;
               for (int j = 0; j < 8; j++) m_mode[t_base + j] = int'((bus_wdata >> (2 * j)) & 32'h3);
            end
            if (bus_addr >= 8'h10 && bus_addr <= 8'h2C && bus_addr[1:0] == 2'b00) begin
               t_k = (int'(bus_addr) - 16) / 4;
               m_lvl[2 * t_k]     = int'(bus_wdata & 32'h7);
               m_lvl[2 * t_k + 1] = int'((bus_wdata >> 8) & 32'h7);
            end
            if (bus_addr == 8'h40) m_mask = int'(bus_wdata & 32'h7);
         end
      end
   end

   function automatic void mdl_win(output bit v, output int id, output int lv);
      bit act;
      v = 0; id = 0; lv = 0;
      for (int i = 0; i < 16; i++) begin
         act = (m_mode[i] >= 2) ? mlat[i] : (ms2[i] == m_mode[i][0]);
         if (act && m_lvl[i] > m_mask && (!v || m_lvl[i] > lv)) begin
            v = 1; id = i; lv = m_lvl[i];
         end
      end
   endfunction

   function automatic logic [31:0] mdl_rd(input logic [7:0] a);
      logic [31:0] r;
      bit v; int id, lv;
      r = 0;
      if (a == 8'h00) r[0] = m_en;
      if (a == 8'h04 || a == 8'h08)
         for (int j = 0; j < 8; j++) r[2*j +: 2] = 2'(m_mode[(a == 8'h08 ? 8 : 0) + j]);
      if (a >= 8'h10 && a <= 8'h2C && a[1:0] == 2'b00) begin
         r[2:0]  = 3'(m_lvl[2 * ((int'(a) - 16) / 4)]);
         r[10:8] = 3'(m_lvl[2 * ((int'(a) - 16) / 4) + 1]);
      end
      if (a == 8'h40) r[2:0] = 3'(m_mask);
      if (a == 8'hA0) begin
         mdl_win(v, id, lv);
         r[16] = !v; r[10:8] = 3'(lv); r[4:0] = 5'(id);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   bit c_v; int c_id, c_lv;
   always @(negedge clk) begin
      if (cmp_on) begin
         mdl_win(c_v, c_id, c_lv);
         chk({cur_req, " model irq"}, {31'b0, cpu_irq}, {31'b0, m_en && c_v});
         chk({cur_req, " model rdata"}, bus_rdata, mdl_rd(bus_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_addr = 8'hA0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); #1;
      bus_addr = a;
      #2 chk(req, bus_rdata, exp);
   endtask

   task automatic drive(input logic [15:0] v);
      @(negedge clk); #1;
      irq_lines = v;
   endtask

   task automatic irq_chk(input logic exp, input string req);
      @(negedge clk); #3;
      chk(req, {31'b0, cpu_irq}, {31'b0, exp});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_on = 1'b1;
      #1 rst_n = 1'b1;

      cur_req = "R1";
      irq_chk(1'b0, "R1 irq after reset");
      rd_chk(8'hA0, 32'h0001_0000, "R1 R10 status after reset");
      rd_chk(8'h00, 32'h0, "R1 enable after reset");
      rd_chk(8'h04, 32'h0, "R1 mode after reset");
      rd_chk(8'h10, 32'h0, "R1 level after reset");
      rd_chk(8'h40, 32'h0, "R1 mask after reset");

      cur_req = "R3";
      wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, 32'h0000_FFFF, "R3 mode upper bits");
      wr(8'h04, 32'h0000_00E4); rd_chk(8'h04, 32'h0000_00E4, "R3 mode packing low");
      wr(8'h08, 32'h0000_00C0); rd_chk(8'h08, 32'h0000_00C0, "R3 mode packing high");
      wr(8'h04, 32'h0); wr(8'h08, 32'h0);

      cur_req = "R4";
      wr(8'h10, 32'hFFFF_FFFF); rd_chk(8'h10, 32'h0000_0707, "R4 level packing");
      wr(8'h10, 32'h0);

      cur_req = "R5";
      wr(8'h18, 32'h0000_0300);
      wr(8'h00, 32'h1);
      drive(16'hFFDF);
      irq_chk(1'b0, "R5 sync latency low");
      irq_chk(1'b1, "R5 active low request");
      rd_chk(8'hA0, 32'h0000_0305, "R10 status fields");

      cur_req = "R2";
      wr(8'h00, 32'h0);
      irq_chk(1'b0, "R2 disabled output");
      rd_chk(8'hA0, 32'h0000_0305, "R2 status while disabled");
      wr(8'h00, 32'h1);
      irq_chk(1'b1, "R2 re-enabled");

      cur_req = "R5";
      wr(8'h04, 32'h0000_0400);
      irq_chk(1'b0, "R5 high mode line low");
      drive(16'hFFFF);
      irq_chk(1'b0, "R5 sync latency high");
      irq_chk(1'b1, "R5 active high request");
      wr(8'h04, 32'h0);
      irq_chk(1'b0, "R5 low mode line high");

      cur_req = "R4";
      drive(16'hFFDF);
      irq_chk(1'b0, "R4 pre");
      irq_chk(1'b1, "R4 request present");
      wr(8'h18, 32'h0);
      irq_chk(1'b0, "R4 level zero disables");
      rd_chk(8'hA0, 32'h0001_0000, "R4 R10 none pending");
      drive(16'hFFFF);
      repeat (3) @(negedge clk);

      cur_req = "R6";
      wr(8'h04, 32'h0000_00C0);
      wr(8'h14, 32'h0000_0200);
      drive(16'hFFF7);
      repeat (4) @(negedge clk);
      irq_chk(1'b0, "R6 falling ignored in rising mode");
      drive(16'hFFFF);
      irq_chk(1'b0, "R6 latch e1");
      irq_chk(1'b0, "R6 latch e2");
      irq_chk(1'b1, "R6 latch set e3");
      drive(16'hFFF7);
      repeat (5) @(negedge clk);
      irq_chk(1'b1, "R6 latch holds");
      rd_chk(8'hA0, 32'h0000_0203, "R6 status");

      cur_req = "R7";
      wr(8'h60, 32'h0000_0003);
      rd_chk(8'hA0, 32'h0000_0203, "R7 unarmed clear ignored");
      wr(8'h60, 32'h0000_0104);
      rd_chk(8'hA0, 32'h0000_0203, "R7 other index untouched");
      wr(8'h60, 32'h0000_0103);
      irq_chk(1'b0, "R7 armed clear");
      rd_chk(8'hA0, 32'h0001_0000, "R7 status after clear");
      rd_chk(8'h60, 32'h0, "R11 clear reads zero");

      cur_req = "R6";
      wr(8'h04, 32'h0000_00C2);
      wr(8'h10, 32'h0000_0001);
      drive(16'hFFF6);
      repeat (3) @(negedge clk);
      irq_chk(1'b1, "R6 falling latch");
      rd_chk(8'hA0, 32'h0000_0100, "R6 falling status");

      cur_req = "R8";
      wr(8'h08, 32'h0000_0004);
      wr(8'h20, 32'h0000_0400);
      rd_chk(8'hA0, 32'h0000_0409, "R9 higher level wins");
      wr(8'h40, 32'h4);
      rd_chk(8'hA0, 32'h0001_0000, "R8 mask equal blocks");
      irq_chk(1'b0, "R8 masked output");
      wr(8'h40, 32'h3);
      rd_chk(8'hA0, 32'h0000_0409, "R8 above mask");
      wr(8'h40, 32'h1);
      wr(8'h20, 32'h0);
      rd_chk(8'hA0, 32'h0001_0000, "R8 level equals mask");
      wr(8'h40, 32'h0);
      rd_chk(8'hA0, 32'h0000_0100, "R8 mask zero");
      wr(8'h40, 32'hFFFF_FFF8);
      rd_chk(8'h40, 32'h0, "R8 mask field bits");
      rd_chk(8'hA0, 32'h0000_0100, "R8 mask upper bits ignored");

      cur_req = "R9";
      wr(8'h20, 32'h0000_0400);
      wr(8'h08, 32'h0000_0104);
      wr(8'h28, 32'h0000_0004);
      rd_chk(8'hA0, 32'h0000_0409, "R9 tie lower index");
      wr(8'h28, 32'h0000_0006);
      rd_chk(8'hA0, 32'h0000_060C, "R9 higher level higher index");
      irq_chk(1'b1, "R9 output");
      wr(8'h28, 32'h0000_0004);
      rd_chk(8'hA0, 32'h0000_0409, "R9 tie again");

      cur_req = "R11";
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'hA0, 32'h0);
      rd_chk(8'h80, 32'h0, "R11 status word zero");
      rd_chk(8'h0C, 32'h0, "R11 hole 0x0C");
      rd_chk(8'h30, 32'h0, "R11 hole 0x30");
      rd_chk(8'hFC, 32'h0, "R11 hole 0xFC");
      rd_chk(8'h00, 32'h1, "R11 enable untouched");
      rd_chk(8'hA0, 32'h0000_0409, "R11 state untouched");

      cur_req = "R12";
      wr(8'h20, 32'h0);
      wr(8'h28, 32'h0);
      rd_chk(8'hA0, 32'h0000_0100, "R12 latch present");
      wr(8'h04, 32'h0000_00C1);
      rd_chk(8'hA0, 32'h0001_0000, "R12 level mode line low");
      wr(8'h04, 32'h0000_00C2);
      rd_chk(8'hA0, 32'h0001_0000, "R12 latch discarded");
      irq_chk(1'b0, "R12 no request");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule